// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

This block holds eight timer channels, numbered 4 to 11. Each channel has a counter, a match register and a control register, all reached over a simple word-wide register bus. A three-bit rate field in each control register picks one of four tick-enable inputs. The tick enables come from prescalers outside the block, nominally at 32768 Hz, 1 kHz, 1 Hz and 1 MHz. A rate field of 0 or 5 to 7 freezes the counter. When the selected tick pulses, a running counter advances by one.

A channel raises a match when the counter it watches steps onto its match value. Control bits decide several things:
- whether the channel is re-armed after a match;
- whether the match clears the channel's own counter;
- whether a channel borrows a neighbour's counter instead of its own;
- whether reading the counter of channel 9 or 11 also latches the counter of the channel just below it into a snapshot register.

Matches set bits in a status register, gated by an enable register. All eight channels drive one shared interrupt line. The line stays high while any status bit is set.

Bus writes take effect at the next clock edge. A read returns its data on `bus_rdata` one cycle after `bus_re`.

Top module: `mt_timer_bank`

## Requirements
- R1: After reset every counter, match, control, enable, status and snapshot register reads 0, and `irq` and `bus_rdata` are 0.
- R2: A counter whose rate field (control bits [2:0]) is 1, 2, 3 or 4 advances by one on each cycle in which `tick_en[0]`, `tick_en[1]`, `tick_en[2]` or `tick_en[3]` respectively is high. Codes 0, 5, 6 and 7 hold the counter, and reads return the held value.
- R3: A bus write to a counter (byte offsets 0x40 + 4*(n-4)) loads the written value at the next edge, and it overrides an increment in the same cycle.
- R4: Control registers (0xC0 + 4*(n-4)) keep bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11. Higher bits read back as 0.
- R5: With control bit 7 clear, channels 5, 6 and 7 do not advance their own counters. Channels 4 and 5 compare against channel 4's counter, and channels 6 and 7 compare against channel 6's counter. With bit 7 set, a channel counts and compares on its own counter.
- R6: With control bit 7 clear, the counters of channels 9 and 11 hold. On channels 8 to 11, control bit 8 set holds the counter whatever the rate field says.
- R7: With control bit 3 set, a match loads 0 into the channel's own counter on the matching edge.
- R8: With control bit 6 set, the channel matches again on every later arrival at its match value. With bit 6 clear, a match disarms the channel until a bus write to its match register (0x80 + 4*(n-4)) or its counter.
- R9: A read of the counter of channel 9 or 11 whose control bit 9 is set copies the counter of channel 8 or 10 into the snapshot register (0x20). Any other read leaves the snapshot unchanged.
- R10: A match of channel n sets status bit n (register 0x14) only if enable bit n (register 0x1C, bits [11:4]) is set. `irq` rises on the same edge as the status bit.
- R11: Writing 1s to status bits clears them. `irq` stays high until status bits [11:4] are all clear. A match in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| tick_en | input | 4 | Rate enables: 32768 Hz, 1 kHz, 1 Hz, 1 MHz |
| irq | output | 1 | Shared match interrupt |

## Verification
Register writes, counter steps, match clears, status bits and `irq` all change on the edge that samples the stimulus. A check made one cycle after the stimulus therefore sees the new state. A read's data appears on `bus_rdata` one edge after the strobe.

The bench applies every stimulus for exactly one cycle, starting at a falling edge. It samples `irq` and read data at the next falling edge, which is the first point where the registered result is valid and still stable. Same-cycle cases are driven in a single cycle: a counter load together with a tick, and a status clear against pending matches.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W   = 8;
  localparam int CTRL_W   = 10;
  localparam int CH_BASE  = 4;   // channel number of slot 0
  localparam int LOW_GRP  = 4;   // slots with 8-bit control and pair sharing

  localparam logic [CTRL_W-1:0] LOW_MASK  = 10'h0FF;
  localparam logic [CTRL_W-1:0] HIGH_MASK = 10'h3FF;

  // control bit positions
  localparam int CB_CLR  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_HALT = 8;
  localparam int CB_SNAP = 9;

  // address map: bits [7:5] pick a bank, bits [4:2] pick the slot
  localparam logic [2:0] RG_CNT   = 3'b010;
  localparam logic [2:0] RG_MATCH = 3'b100;
  localparam logic [2:0] RG_CTRL  = 3'b110;

  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SNAP = 8'h20;
endpackage

// File: rtl/mt_rate_sel.sv
module mt_rate_sel #(
  parameter int NTICK = 4
) (
  input  logic [2:0]       sel,
  input  logic [NTICK-1:0] ticks,
  output logic             pulse
);
  always_comb begin
    pulse = 1'b0;
    for (int k = 0; k < NTICK; k++) begin
      if (sel == 3'(k + 1)) pulse = ticks[k];
    end
  end
endmodule

// File: rtl/mt_channel.sv
module mt_channel import mt_pkg::*; #(
  parameter int DW    = 32,
  parameter int NTICK = 4,
  parameter int IDX   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cnt,
  input  logic              wr_match,
  input  logic              wr_ctrl,
  input  logic [DW-1:0]     wdata,
  input  logic [NTICK-1:0]  ticks,
  input  logic [DW-1:0]     src_cnt,
  input  logic              src_inc,
  output logic [DW-1:0]     cnt,
  output logic [DW-1:0]     match,
  output logic [CTRL_W-1:0] ctrl,
  output logic              inc,
  output logic              hit
);
  localparam bit IS_LOW   = (IDX < LOW_GRP);
  localparam bit NEED_OWN = IS_LOW ? (IDX != 0) : ((IDX % 2) == 1);
  localparam logic [CTRL_W-1:0] MASK = IS_LOW ? LOW_MASK : HIGH_MASK;

  logic [DW-1:0]     cnt_q, match_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              armed_q, rate_pulse, run_ok;

  mt_rate_sel #(.NTICK(NTICK)) u_rate (
    .sel   (ctrl_q[2:0]),
    .ticks (ticks),
    .pulse (rate_pulse)
  );

  assign run_ok = !ctrl_q[CB_HALT] && (NEED_OWN ? ctrl_q[CB_OWN] : 1'b1);
  assign inc    = rate_pulse && run_ok && !wr_cnt;
  assign hit    = armed_q && src_inc && (DW'(src_cnt + 1'b1) == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (wr_cnt)                      cnt_q <= wdata;
      else if (hit && ctrl_q[CB_CLR])  cnt_q <= '0;
      else if (inc)                    cnt_q <= cnt_q + 1'b1;

      if (wr_match) match_q <= wdata;
      if (wr_ctrl)  ctrl_q  <= wdata[CTRL_W-1:0] & MASK;

      if (wr_cnt || wr_match)          armed_q <= 1'b1;
      else if (hit && !ctrl_q[CB_PER]) armed_q <= 1'b0;
    end
  end

  assign cnt   = cnt_q;
  assign match = match_q;
  assign ctrl  = ctrl_q;

  // R2: without a load or a match clear the counter holds or steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && !(hit && ctrl_q[CB_CLR])) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R3: a counter load lands on the next edge
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wdata)));

  // R7: clear on match
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (hit && ctrl_q[CB_CLR] && !wr_cnt) |=> (cnt_q == '0));

  // R8: one-shot disarms, so no second match until a rewrite
  a_r8_oneshot: assert property (@(posedge clk) disable iff (rst)
    (hit && !ctrl_q[CB_PER] && !wr_cnt && !wr_match) |=> !hit);
endmodule

// File: rtl/mt_irq_ctrl.sv
module mt_irq_ctrl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] en,
  output logic [NCH-1:0] status,
  output logic           irq
);
  logic [NCH-1:0] en_q, st_q, st_next;
  logic           irq_q;

  assign st_next = (st_q & ~(wr_clr ? wdata : '0)) | (hit & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata;
      st_q  <= st_next;
      irq_q <= |st_next;
    end
  end

  assign en     = en_q;
  assign status = st_q;
  assign irq    = irq_q;

  // R10: a status bit rises only where the enable was set
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  // R11: the line follows the status bits
  a_r11_line: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|st_q));
endmodule

// File: rtl/mt_timer_bank.sv
module mt_timer_bank import mt_pkg::*; #(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int NTICK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NTICK-1:0]  tick_en,
  output logic              irq
);
  logic [2:0] region, slot;
  logic       aligned;
  assign region  = bus_addr[7:5];
  assign slot    = bus_addr[4:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic [DW-1:0]     cnt_a   [NCH];
  logic [DW-1:0]     match_a [NCH];
  logic [CTRL_W-1:0] ctrl_a  [NCH];
  logic [NCH-1:0]    inc_v, hit_v, en_v, st_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int PAIR = (g < LOW_GRP) ? (g & ~1) : g;
    logic          wc, wm, wk;
    logic [DW-1:0] s_cnt;
    logic          s_inc;

    assign wc = bus_we && aligned && region == RG_CNT   && slot == 3'(g);
    assign wm = bus_we && aligned && region == RG_MATCH && slot == 3'(g);
    assign wk = bus_we && aligned && region == RG_CTRL  && slot == 3'(g);

    assign s_cnt = ctrl_a[g][CB_OWN] ? cnt_a[g] : cnt_a[PAIR];
    assign s_inc = ctrl_a[g][CB_OWN] ? inc_v[g] : inc_v[PAIR];

    mt_channel #(.DW(DW), .NTICK(NTICK), .IDX(g)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_cnt   (wc),
      .wr_match (wm),
      .wr_ctrl  (wk),
      .wdata    (bus_wdata),
      .ticks    (tick_en),
      .src_cnt  (s_cnt),
      .src_inc  (s_inc),
      .cnt      (cnt_a[g]),
      .match    (match_a[g]),
      .ctrl     (ctrl_a[g]),
      .inc      (inc_v[g]),
      .hit      (hit_v[g])
    );
  end

  mt_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_we && bus_addr == OFF_IEN),
    .wr_clr (bus_we && bus_addr == OFF_STAT),
    .wdata  (bus_wdata[CH_BASE +: NCH]),
    .hit    (hit_v),
    .en     (en_v),
    .status (st_v),
    .irq    (irq)
  );

  // snapshot capture on a counter read of an odd upper slot
  logic [DW-1:0] snap_q;
  logic          snap_take;
  assign snap_take = bus_re && aligned && region == RG_CNT && slot[0] &&
                     (slot >= 3'(LOW_GRP)) && ctrl_a[slot][CB_SNAP];

  always_ff @(posedge clk) begin
    if (rst)            snap_q <= '0;
    else if (snap_take) snap_q <= cnt_a[slot - 3'd1];
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (region)
        RG_CNT:   rd_val = cnt_a[slot];
        RG_MATCH: rd_val = match_a[slot];
        RG_CTRL:  rd_val = DW'(ctrl_a[slot]);
        default: begin
          if (bus_addr == OFF_SNAP)      rd_val = snap_q;
          else if (bus_addr == OFF_STAT) rd_val[CH_BASE +: NCH] = st_v;
          else if (bus_addr == OFF_IEN)  rd_val[CH_BASE +: NCH] = en_v;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  // R9: the snapshot only moves on a bus read
  a_r9_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(snap_q));
endmodule

// File: tb/sim_mt_timer_bank.sv
module sim_mt_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic        irq;

  int checks = 0, fails = 0;
  int cycles = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  mt_timer_bank u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] tk = 4'b0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_we = 1'b0; tick_en = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [3:0] tk, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = tk;
      @(negedge clk);
      tick_en = '0;
    end
  endtask

  task automatic quiet();
    for (int i = 0; i < 8; i++) wr(8'hC0 + 8'(4 * i), 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'hFFF);
  endtask

  task automatic t_reset();
    check("R1 rdata", bus_rdata, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h40, rv); check("R1 counter", rv, 0);
    rd(8'hD0, rv); check("R1 control", rv, 0);
    rd(8'h14, rv); check("R1 status", rv, 0);
    rd(8'h20, rv); check("R1 snapshot", rv, 0);
  endtask

  task automatic t_rates();
    wr(8'hC0, 32'h1);
    pulse(4'b0001, 3); pulse(4'b0010, 1);
    rd(8'h40, rv); check("R2 rate1 ignores other ticks", rv, 3);
    wr(8'hC0, 32'h2); pulse(4'b0010, 1); pulse(4'b0001, 1);
    rd(8'h40, rv); check("R2 rate2", rv, 4);
    wr(8'hC0, 32'h3); pulse(4'b0100, 1);
    wr(8'hC0, 32'h4); pulse(4'b1000, 2);
    rd(8'h40, rv); check("R2 rate3 and rate4", rv, 7);
    wr(8'hC0, 32'h5); pulse(4'b1111, 2);
    rd(8'h40, rv); check("R2 code5 holds", rv, 7);
    wr(8'hC0, 32'h0); pulse(4'b1111, 2);
    rd(8'h40, rv); check("R2 code0 holds", rv, 7);
    quiet();
  endtask

  task automatic t_load();
    wr(8'hD0, 32'h1);
    wr(8'h50, 32'd100, 4'b0001);
    rd(8'h50, rv); check("R3 load beats tick", rv, 100);
    pulse(4'b0001, 1);
    rd(8'h50, rv); check("R3 counts on from load", rv, 101);
    quiet();
  endtask

  task automatic t_width();
    wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'hC4, rv); check("R4 low channel width", rv, 32'hFF);
    wr(8'hDC, 32'hFFFF_FFFF);
    rd(8'hDC, rv); check("R4 high channel width", rv, 32'h3FF);
    quiet();
  endtask

  task automatic t_share();
    wr(8'h40, 0); wr(8'h44, 0);
    wr(8'hC0, 32'h1); wr(8'hC4, 32'h1);
    wr(8'h84, 32'd2); wr(8'h1C, 32'h020);
    pulse(4'b0001, 1);
    check("R5 no early match", {31'b0, irq}, 0);
    pulse(4'b0001, 1);
    check("R5 match on shared counter irq", {31'b0, irq}, 1);
    rd(8'h14, rv); check("R5 status bit5", rv, 32'h020);
    rd(8'h44, rv); check("R5 own counter idle", rv, 0);
    wr(8'hC4, 32'h81); pulse(4'b0001, 1);
    rd(8'h44, rv); check("R5 own counter with bit7", rv, 1);
    quiet();
  endtask

  task automatic t_stop_odd();
    wr(8'h54, 0); wr(8'hD4, 32'h01); pulse(4'b0001, 1);
    rd(8'h54, rv); check("R6 odd channel halted", rv, 0);
    wr(8'hD4, 32'h81); pulse(4'b0001, 1);
    rd(8'h54, rv); check("R6 odd channel with bit7", rv, 1);
    wr(8'h50, 32'd10); wr(8'hD0, 32'h101); pulse(4'b0001, 1);
    rd(8'h50, rv); check("R6 bit8 halts", rv, 10);
    wr(8'hD0, 32'h001); pulse(4'b0001, 1);
    rd(8'h50, rv); check("R6 resumes without bit8", rv, 11);
    quiet();
  endtask

  task automatic t_periodic();
    wr(8'h58, 0); wr(8'h98, 32'd3); wr(8'h1C, 32'h400);
    wr(8'hD8, 32'h49);
    pulse(4'b0001, 3);
    rd(8'h14, rv); check("R8 periodic first match", rv, 32'h400);
    rd(8'h58, rv); check("R7 cleared on match", rv, 0);
    wr(8'h14, 32'h400);
    check("R11 irq low after clear", {31'b0, irq}, 0);
    pulse(4'b0001, 3);
    rd(8'h14, rv); check("R8 periodic second match", rv, 32'h400);
    quiet();
  endtask

  task automatic t_oneshot();
    wr(8'h5C, 0); wr(8'h9C, 32'd2); wr(8'h1C, 32'h800);
    wr(8'hDC, 32'h89);
    pulse(4'b0001, 2);
    rd(8'h14, rv); check("R8 one-shot match", rv, 32'h800);
    wr(8'h14, 32'h800);
    pulse(4'b0001, 2);
    rd(8'h14, rv); check("R8 disarmed after match", rv, 0);
    rd(8'h5C, rv); check("R8 counter kept running", rv, 2);
    wr(8'h9C, 32'd4);
    pulse(4'b0001, 2);
    rd(8'h14, rv); check("R8 rearmed by match write", rv, 32'h800);
    quiet();
  endtask

  task automatic t_gate();
    wr(8'h40, 0); wr(8'h80, 32'd1); wr(8'h1C, 32'h0); wr(8'hC0, 32'h1);
    pulse(4'b0001, 1);
    rd(8'h14, rv); check("R10 disabled match sets nothing", rv, 0);
    check("R10 irq stays low", {31'b0, irq}, 0);
    quiet();
  endtask

  task automatic t_irq_multi();
    wr(8'h40, 0); wr(8'h80, 32'd1); wr(8'hC0, 32'h1);
    wr(8'h48, 0); wr(8'h88, 32'd1); wr(8'hC8, 32'h81);
    wr(8'h1C, 32'h050);
    pulse(4'b0001, 1);
    rd(8'h14, rv); check("R10 two channels pending", rv, 32'h050);
    wr(8'h14, 32'h010);
    check("R11 irq held by remaining bit", {31'b0, irq}, 1);
    rd(8'h14, rv); check("R11 partial clear", rv, 32'h040);
    wr(8'h14, 32'h040);
    check("R11 irq drops when all clear", {31'b0, irq}, 0);
    quiet();
  endtask

  task automatic t_snapshot();
    wr(8'h50, 32'd55); wr(8'hD4, 32'h200);
    rd(8'h54, rv); rd(8'h20, rv); check("R9 snapshot of channel 8", rv, 55);
    wr(8'h50, 32'd77); wr(8'hD4, 32'h0);
    rd(8'h54, rv); rd(8'h20, rv); check("R9 no capture without bit9", rv, 55);
    wr(8'h58, 32'd33); wr(8'hDC, 32'h200);
    rd(8'h5C, rv); rd(8'h20, rv); check("R9 snapshot of channel 10", rv, 33);
    quiet();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rates();
    t_load();
    t_width();
    t_share();
    t_stop_odd();
    t_periodic();
    t_oneshot();
    t_gate();
    t_irq_multi();
    t_snapshot();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule